// File: doc/BRIEF.md
# Two-Wide Issue Steering for Asymmetric Pipes

This block sits behind the two instruction registers of an in-order, two-wide pipeline. Every cycle it decodes the older and the younger held instruction side by side, determines the class of each, and looks for a read-after-write dependency of the younger on the older. It then routes each instruction to one of two execution pipes that do not accept the same instruction classes. Pipe A takes memory operations, pipe B takes branches, and both take plain arithmetic.

The routing decision and the number of instructions taken are produced combinationally, so the fetch side learns in the same cycle how many instruction registers to refill. The routed instruction words and their valid flags are captured in a pair of issue registers that feed the two pipes. A stall input freezes the issue registers and forces the consumed count to zero.

Instruction fields used by the block, with the default 32-bit word and 5-bit register numbers: class in bits [31:30] (00 arithmetic, 01 load, 10 store, 11 branch), destination in [29:25], first source in [24:20], second source in [19:15]. Lower bits are carried through untouched.

Top module: `dual_issue_steer`

## Requirements
- R1: While reset is held low at a clock edge, both pipe valid flags and both pipe words are cleared to zero.
- R2: A load (class 01) or store (class 10) is only ever placed on pipe A. A branch (class 11) is only ever placed on pipe B.
- R3: When the older slot is not valid, nothing issues and the consumed count is 0, even if the younger slot is valid.
- R4: An arithmetic instruction (class 00) goes to pipe A, except when it is the older of an issued pair whose younger is a load or store, in which case it goes to pipe B. In a pair of two arithmetic instructions, the older goes to pipe A and the younger to pipe B.
- R5: When both slots hold memory operations, or both hold branches, only the older issues and the consumed count is 1.
- R6: When the older instruction writes a destination register that is nonzero and equal to either source field of the younger, only the older issues (consumed count 1). Both source fields are compared whatever the younger's class.
- R7: Register 0 never creates a dependency, and stores and branches write no register, so neither their destination field nor register 0 blocks a pair.
- R8: The consumed count (0, 1 or 2) is valid in the same cycle as the slot inputs and equals the number of valid flags set on the pipes after the next clock edge.
- R9: While stall is high, the consumed count is 0 and the pipe valid flags and words keep their values across the clock edge.
- R10: A pipe that receives no instruction at an edge shows valid 0 and word 0 after it; a pipe that receives one shows the routed word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_i | input | 1 | Freeze issue registers, take nothing |
| slot0_valid | input | 1 | Older instruction register holds an instruction |
| slot0_insn | input | INSN_W | Older instruction word |
| slot1_valid | input | 1 | Younger instruction register holds an instruction |
| slot1_insn | input | INSN_W | Younger instruction word |
| consumed | output | 2 | Instructions taken this cycle (0, 1 or 2) |
| pa_valid | output | 1 | Pipe A issue register holds an instruction |
| pa_insn | output | INSN_W | Word issued to pipe A |
| pb_valid | output | 1 | Pipe B issue register holds an instruction |
| pb_insn | output | INSN_W | Word issued to pipe B |

## Verification
The consumed count is a combinational function of the slot inputs and stall, so the bench reads it one nanosecond after driving the inputs on the falling edge and before the next rising edge. The pipe valid flags and words change only at the rising edge that follows, so they are compared one nanosecond after that edge against a bench model updated in the same step, which also holds its previous state when stall was high. Directed pairs cover every class combination, dependencies through each source field, register zero and the store and branch destination fields, followed by random pairs drawn from only four register numbers so that dependencies occur often.

// File: rtl/dis_pkg.sv
// Package: shared types for the two-wide issue steering block.
// Assumes the class encoding below is fixed by the instruction format.
package dis_pkg;

    typedef enum logic [1:0] {
        CLS_ALU    = 2'b00,
        CLS_LOAD   = 2'b01,
        CLS_STORE  = 2'b10,
        CLS_BRANCH = 2'b11
    } insn_cls_e;

    typedef enum logic {
        PIPE_A = 1'b0,
        PIPE_B = 1'b1
    } pipe_sel_e;

    localparam int unsigned NUM_SLOTS = 2;

    // True for classes that must use the memory pipe (A).
    function automatic logic cls_is_mem(insn_cls_e c);
        return (c == CLS_LOAD) || (c == CLS_STORE);
    endfunction

    // True for classes that must use the branch pipe (B).
    function automatic logic cls_is_branch(insn_cls_e c);
        return c == CLS_BRANCH;
    endfunction

    // True for classes that write a destination register.
    function automatic logic cls_writes(insn_cls_e c);
        return (c == CLS_ALU) || (c == CLS_LOAD);
    endfunction

endpackage

// File: rtl/dis_decode.sv
// Module: dis_decode
// Extracts class and register fields from one held instruction word.
// Assumes class sits in the top two bits, then destination, first source
// and second source, each REG_W wide; remaining low bits are payload.
module dis_decode
    import dis_pkg::*;
#(
    parameter int unsigned INSN_W = 32,
    parameter int unsigned REG_W  = 5
) (
    input  logic [INSN_W-1:0] insn,
    output insn_cls_e         cls,
    output logic              needs_a,
    output logic              needs_b,
    output logic              writes,
    output logic [REG_W-1:0]  rd,
    output logic [REG_W-1:0]  rs1,
    output logic [REG_W-1:0]  rs2
);
    localparam int unsigned CLS_LSB = INSN_W - 2;
    localparam int unsigned RD_LSB  = CLS_LSB - REG_W;
    localparam int unsigned RS1_LSB = RD_LSB - REG_W;
    localparam int unsigned RS2_LSB = RS1_LSB - REG_W;

    // Field extraction and class attributes.
    always_comb begin
        cls     = insn_cls_e'(insn[INSN_W-1:CLS_LSB]);
        rd      = insn[RD_LSB  +: REG_W];
        rs1     = insn[RS1_LSB +: REG_W];
        rs2     = insn[RS2_LSB +: REG_W];
        needs_a = cls_is_mem(cls);
        needs_b = cls_is_branch(cls);
        writes  = cls_writes(cls);
    end

    generate
        if (RS2_LSB > 0) begin : g_payload
            logic unused_payload;
            assign unused_payload = ^insn[RS2_LSB-1:0];
        end
    endgenerate

endmodule

// File: rtl/dis_hazard.sv
// Module: dis_hazard
// Flags a read-after-write dependency of the younger instruction on the
// older one. Assumes register 0 is a constant and carries no dependency.
module dis_hazard #(
    parameter int unsigned REG_W = 5
) (
    input  logic             old_writes,
    input  logic [REG_W-1:0] old_rd,
    input  logic [REG_W-1:0] yng_rs1,
    input  logic [REG_W-1:0] yng_rs2,
    output logic             raw
);
    // Destination-to-source compare, register zero excluded.
    always_comb begin
        raw = old_writes && (old_rd != '0) &&
              ((old_rd == yng_rs1) || (old_rd == yng_rs2));
    end
endmodule

// File: rtl/dis_steer.sv
// Module: dis_steer
// Decides which slots issue and which pipe each one uses.
// Assumes pipe A serves memory operations, pipe B serves branches, and
// arithmetic may use either. Issue is strictly in program order.
module dis_steer
    import dis_pkg::*;
(
    input  logic      stall,
    input  logic      v0,
    input  logic      v1,
    input  logic      a0,
    input  logic      b0,
    input  logic      a1,
    input  logic      b1,
    input  logic      raw,
    output logic      iss0,
    output logic      iss1,
    output pipe_sel_e pipe0,
    output pipe_sel_e pipe1,
    output logic [1:0] count
);
    logic clash;

    // Issue decision: older first, younger only if it can pair.
    always_comb begin
        clash = (a0 && a1) || (b0 && b1);
        iss0  = v0 && !stall;
        iss1  = iss0 && v1 && !raw && !clash;
        count = {1'b0, iss0} + {1'b0, iss1};
    end

    // Pipe choice: restricted classes first, arithmetic fills the gap.
    always_comb begin
        if (a0)                 pipe0 = PIPE_A;
        else if (b0)            pipe0 = PIPE_B;
        else if (iss1 && a1)    pipe0 = PIPE_B;
        else                    pipe0 = PIPE_A;

        if (a1)                 pipe1 = PIPE_A;
        else if (b1)            pipe1 = PIPE_B;
        else                    pipe1 = (pipe0 == PIPE_A) ? PIPE_B : PIPE_A;
    end
endmodule

// File: rtl/dual_issue_steer.sv
// Module: dual_issue_steer (top)
// Decodes two held instructions, checks their dependency, steers them to
// two asymmetric pipes and registers the result for the pipes.
// Assumes slot 0 is always the older instruction; synchronous active-low
// reset; stall holds the issue registers and takes nothing.
module dual_issue_steer
    import dis_pkg::*;
#(
    parameter int unsigned INSN_W = 32,
    parameter int unsigned REG_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stall_i,
    input  logic              slot0_valid,
    input  logic [INSN_W-1:0] slot0_insn,
    input  logic              slot1_valid,
    input  logic [INSN_W-1:0] slot1_insn,
    output logic [1:0]        consumed,
    output logic              pa_valid,
    output logic [INSN_W-1:0] pa_insn,
    output logic              pb_valid,
    output logic [INSN_W-1:0] pb_insn
);
    localparam int unsigned CLS_LSB = INSN_W - 2;

    logic [INSN_W-1:0] slot_insn [NUM_SLOTS];
    insn_cls_e         slot_cls  [NUM_SLOTS];
    logic              slot_a    [NUM_SLOTS];
    logic              slot_b    [NUM_SLOTS];
    logic              slot_wr   [NUM_SLOTS];
    logic [REG_W-1:0]  slot_rd   [NUM_SLOTS];
    logic [REG_W-1:0]  slot_rs1  [NUM_SLOTS];
    logic [REG_W-1:0]  slot_rs2  [NUM_SLOTS];

    logic      raw;
    logic      iss0, iss1;
    pipe_sel_e pipe0, pipe1;
    logic      nxt_a_v, nxt_b_v;
    logic [INSN_W-1:0] nxt_a_w, nxt_b_w;

    assign slot_insn[0] = slot0_insn;
    assign slot_insn[1] = slot1_insn;

    generate
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_dec
            dis_decode #(.INSN_W(INSN_W), .REG_W(REG_W)) u_dec (
                .insn    (slot_insn[s]),
                .cls     (slot_cls[s]),
                .needs_a (slot_a[s]),
                .needs_b (slot_b[s]),
                .writes  (slot_wr[s]),
                .rd      (slot_rd[s]),
                .rs1     (slot_rs1[s]),
                .rs2     (slot_rs2[s])
            );
        end
    endgenerate

    dis_hazard #(.REG_W(REG_W)) u_haz (
        .old_writes (slot_wr[0]),
        .old_rd     (slot_rd[0]),
        .yng_rs1    (slot_rs1[1]),
        .yng_rs2    (slot_rs2[1]),
        .raw        (raw)
    );

    dis_steer u_steer (
        .stall (stall_i),
        .v0    (slot0_valid),
        .v1    (slot1_valid),
        .a0    (slot_a[0]),
        .b0    (slot_b[0]),
        .a1    (slot_a[1]),
        .b1    (slot_b[1]),
        .raw   (raw),
        .iss0  (iss0),
        .iss1  (iss1),
        .pipe0 (pipe0),
        .pipe1 (pipe1),
        .count (consumed)
    );

    // Per-pipe selection of the word to be registered.
    always_comb begin
        nxt_a_v = 1'b0;
        nxt_b_v = 1'b0;
        nxt_a_w = '0;
        nxt_b_w = '0;
        if (iss0) begin
            if (pipe0 == PIPE_A) begin nxt_a_v = 1'b1; nxt_a_w = slot0_insn; end
            else                 begin nxt_b_v = 1'b1; nxt_b_w = slot0_insn; end
        end
        if (iss1) begin
            if (pipe1 == PIPE_A) begin nxt_a_v = 1'b1; nxt_a_w = slot1_insn; end
            else                 begin nxt_b_v = 1'b1; nxt_b_w = slot1_insn; end
        end
    end

    // Issue registers feeding the two pipes; held while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_valid <= 1'b0;
            pa_insn  <= '0;
            pb_valid <= 1'b0;
            pb_insn  <= '0;
        end else if (!stall_i) begin
            pa_valid <= nxt_a_v;
            pa_insn  <= nxt_a_w;
            pb_valid <= nxt_b_v;
            pb_insn  <= nxt_b_w;
        end
    end

    // R2: pipe B never holds a memory operation.
    a_r2_no_mem_on_b: assert property (@(posedge clk) disable iff (!rst_n)
        pb_valid |-> !cls_is_mem(insn_cls_e'(pb_insn[INSN_W-1:CLS_LSB])));

    // R2: pipe A never holds a branch.
    a_r2_no_branch_on_a: assert property (@(posedge clk) disable iff (!rst_n)
        pa_valid |-> !cls_is_branch(insn_cls_e'(pa_insn[INSN_W-1:CLS_LSB])));

    // R3: no issue without an older instruction.
    a_r3_order: assert property (@(posedge clk) disable iff (!rst_n)
        !slot0_valid |-> (consumed == 2'd0));

    // R5: a pair that shares a restricted pipe issues singly.
    a_r5_shared_pipe: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_a[0] && slot_a[1]) || (slot_b[0] && slot_b[1])) |-> (consumed != 2'd2));

    // R6: a dependency found by the compare blocks pairing.
    a_r6_raw_single: assert property (@(posedge clk) disable iff (!rst_n)
        raw |-> (consumed != 2'd2));

    // R8: registered valid flags match the count of the previous cycle.
    a_r8_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_i |=> (({1'b0, pa_valid} + {1'b0, pb_valid}) == $past(consumed)));

    // R9: stall freezes both issue registers.
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> $stable({pa_valid, pa_insn, pb_valid, pb_insn}));

endmodule

// File: tb/dual_issue_steer_tb.sv
`timescale 1ns/1ps
module dual_issue_steer_tb;
    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         stall_i = 1'b0;
    logic         slot0_valid = 1'b0;
    logic [W-1:0] slot0_insn = '0;
    logic         slot1_valid = 1'b0;
    logic [W-1:0] slot1_insn = '0;
    logic [1:0]   consumed;
    logic         pa_valid, pb_valid;
    logic [W-1:0] pa_insn, pb_insn;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model of the issue registers
    logic         m_av = 1'b0, m_bv = 1'b0;
    logic [W-1:0] m_aw = '0, m_bw = '0;

    always #2.5 clk = ~clk;

    dual_issue_steer u_dut (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i),
        .slot0_valid(slot0_valid), .slot0_insn(slot0_insn),
        .slot1_valid(slot1_valid), .slot1_insn(slot1_insn),
        .consumed(consumed),
        .pa_valid(pa_valid), .pa_insn(pa_insn),
        .pb_valid(pb_valid), .pb_insn(pb_insn)
    );

    function automatic logic [W-1:0] mk(input logic [1:0] c, input logic [4:0] d,
                                        input logic [4:0] s1, input logic [4:0] s2,
                                        input logic [14:0] tag);
        return {c, d, s1, s2, tag};
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference: expected count and routing from the requirements.
    task automatic model(input logic v0, input logic [W-1:0] w0,
                         input logic v1, input logic [W-1:0] w1, input logic st,
                         output logic [1:0] cnt, output logic av, output logic [W-1:0] aw,
                         output logic bv, output logic [W-1:0] bw);
        logic [1:0] c0, c1;
        logic mem0, mem1, br0, br1, wr0, dep, pair, old_on_b;
        c0 = w0[31:30]; c1 = w1[31:30];
        mem0 = (c0 == 2'b01) || (c0 == 2'b10);
        mem1 = (c1 == 2'b01) || (c1 == 2'b10);
        br0 = (c0 == 2'b11); br1 = (c1 == 2'b11);
        wr0 = (c0 == 2'b00) || (c0 == 2'b01);
        dep = wr0 && (w0[29:25] != 5'd0) &&
              (w0[29:25] == w1[24:20] || w0[29:25] == w1[19:15]);
        av = 1'b0; bv = 1'b0; aw = '0; bw = '0; cnt = 2'd0;
        if (!st && v0) begin
            pair = v1 && !dep && !(mem0 && mem1) && !(br0 && br1);
            old_on_b = br0 || (pair && c0 == 2'b00 && mem1);
            if (old_on_b) begin bv = 1'b1; bw = w0; end
            else          begin av = 1'b1; aw = w0; end
            cnt = 2'd1;
            if (pair) begin
                cnt = 2'd2;
                if (old_on_b) begin av = 1'b1; aw = w1; end
                else          begin bv = 1'b1; bw = w1; end
            end
        end
    endtask

    task automatic step(input logic v0, input logic [W-1:0] w0,
                        input logic v1, input logic [W-1:0] w1,
                        input logic st, input string req);
        logic [1:0] e_cnt;
        logic e_av, e_bv;
        logic [W-1:0] e_aw, e_bw;
        @(negedge clk);
        slot0_valid = v0; slot0_insn = w0;
        slot1_valid = v1; slot1_insn = w1;
        stall_i = st;
        model(v0, w0, v1, w1, st, e_cnt, e_av, e_aw, e_bv, e_bw);
        #1;
        chk({req, " R8 count"}, {30'd0, consumed}, {30'd0, e_cnt});
        if (!st) begin
            m_av = e_av; m_aw = e_aw; m_bv = e_bv; m_bw = e_bw;
        end
        @(posedge clk);
        #1;
        chk({req, " R10 pipeA valid"}, {31'd0, pa_valid}, {31'd0, m_av});
        chk({req, " R10 pipeA word"},  pa_insn, m_aw);
        chk({req, " R10 pipeB valid"}, {31'd0, pb_valid}, {31'd0, m_bv});
        chk({req, " R10 pipeB word"},  pb_insn, m_bw);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        // R1: reset clears issue registers despite valid inputs
        slot0_valid = 1'b1; slot0_insn = mk(2'b00, 5'd1, 5'd2, 5'd3, 15'h11);
        slot1_valid = 1'b1; slot1_insn = mk(2'b11, 5'd0, 5'd2, 5'd3, 15'h12);
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pipeA valid", {31'd0, pa_valid}, '0);
        chk("R1 pipeB valid", {31'd0, pb_valid}, '0);
        chk("R1 pipeA word", pa_insn, '0);
        chk("R1 pipeB word", pb_insn, '0);
        @(negedge clk);
        rst_n = 1'b1;

        step(1, mk(2'b01, 5'd4, 5'd5, 5'd6, 15'h101), 1, mk(2'b11, 5'd0, 5'd7, 5'd8, 15'h102), 0, "R2 load+branch");
        step(1, mk(2'b11, 5'd0, 5'd5, 5'd6, 15'h111), 1, mk(2'b10, 5'd0, 5'd7, 5'd8, 15'h112), 0, "R2 branch+store");
        step(1, mk(2'b00, 5'd4, 5'd5, 5'd6, 15'h121), 1, mk(2'b01, 5'd9, 5'd7, 5'd8, 15'h122), 0, "R4 alu+load");
        step(1, mk(2'b00, 5'd4, 5'd5, 5'd6, 15'h131), 1, mk(2'b11, 5'd0, 5'd7, 5'd8, 15'h132), 0, "R4 alu+branch");
        step(1, mk(2'b00, 5'd4, 5'd5, 5'd6, 15'h141), 1, mk(2'b00, 5'd9, 5'd7, 5'd8, 15'h142), 0, "R4 alu+alu");
        step(1, mk(2'b11, 5'd0, 5'd5, 5'd6, 15'h145), 1, mk(2'b00, 5'd9, 5'd7, 5'd8, 15'h146), 0, "R4 branch+alu");
        step(1, mk(2'b00, 5'd4, 5'd5, 5'd6, 15'h147), 0, mk(2'b00, 5'd9, 5'd7, 5'd8, 15'h148), 0, "R4 lone alu");
        step(1, mk(2'b01, 5'd4, 5'd5, 5'd6, 15'h151), 1, mk(2'b10, 5'd0, 5'd7, 5'd8, 15'h152), 0, "R5 load+store");
        step(1, mk(2'b11, 5'd0, 5'd5, 5'd6, 15'h161), 1, mk(2'b11, 5'd0, 5'd7, 5'd8, 15'h162), 0, "R5 branch+branch");
        step(1, mk(2'b00, 5'd3, 5'd5, 5'd6, 15'h171), 1, mk(2'b00, 5'd9, 5'd3, 5'd8, 15'h172), 0, "R6 rs1 dep");
        step(1, mk(2'b01, 5'd3, 5'd5, 5'd6, 15'h181), 1, mk(2'b11, 5'd0, 5'd7, 5'd3, 15'h182), 0, "R6 rs2 dep");
        step(1, mk(2'b00, 5'd0, 5'd5, 5'd6, 15'h191), 1, mk(2'b00, 5'd9, 5'd0, 5'd0, 15'h192), 0, "R7 reg zero");
        step(1, mk(2'b10, 5'd3, 5'd5, 5'd6, 15'h1A1), 1, mk(2'b00, 5'd9, 5'd3, 5'd3, 15'h1A2), 0, "R7 store dest");
        step(1, mk(2'b11, 5'd3, 5'd5, 5'd6, 15'h1B1), 1, mk(2'b01, 5'd9, 5'd3, 5'd8, 15'h1B2), 0, "R7 branch dest");
        step(0, mk(2'b00, 5'd3, 5'd5, 5'd6, 15'h1C1), 1, mk(2'b00, 5'd9, 5'd1, 5'd8, 15'h1C2), 0, "R3 older empty");
        step(1, mk(2'b01, 5'd4, 5'd5, 5'd6, 15'h1D1), 1, mk(2'b11, 5'd0, 5'd7, 5'd8, 15'h1D2), 0, "R9 prime");
        step(1, mk(2'b00, 5'd4, 5'd5, 5'd6, 15'h1E1), 1, mk(2'b00, 5'd9, 5'd7, 5'd8, 15'h1E2), 1, "R9 stall");
        step(1, mk(2'b11, 5'd0, 5'd5, 5'd6, 15'h1F1), 0, '0, 0, "R2 lone branch");

        for (int i = 0; i < 3000; i++) begin
            logic [W-1:0] a, b;
            a = {$urandom} ; b = {$urandom};
            a[29:15] = {3'd0, a[26:25], 3'd0, a[21:20], 3'd0, a[16:15]};
            b[29:15] = {3'd0, b[26:25], 3'd0, b[21:20], 3'd0, b[16:15]};
            step(($urandom % 8) != 0, a, ($urandom % 6) != 0, b,
                 ($urandom % 10) == 0, "R2 R4 R5 R6 R9 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule